// File: doc/BRIEF.md
# Bit-Serial CRC Generator and Checker

This block runs a cyclic redundancy check over a message that arrives one bit per clock, using a single shift register with exclusive-OR feedback taps. All of its arithmetic is modulo 2. A compile-time parameter picks the generator polynomial, and that choice also fixes the register width. The register is then reused for both directions of a link.

On the sending side, the message passes through the block and appears on the serial output. Once the last message bit has been taken in, the block appends the register contents as the frame check sequence. The frame that results divides evenly by the generator. On the receiving side, the whole frame, check bits included, is shifted in. The block then reports whether the remainder left in the register is zero; a nonzero remainder means the frame was corrupted.

A frame begins with a bit that has the start flag set and ends with a bit that has the end flag set. The level of the mode input on the start bit decides whether the frame is generated or checked.

Top module: `serial_crc_engine`

## Requirements
- R1: The `KIND` parameter selects one of four generators: 12-bit (0x80F), 16-bit (0x8005), 16-bit CCITT (0x1021, the default) or 32-bit (0x04C11DB7). Each value is written without its top term, and the register width equals the generator degree. With the default generator, the 72-bit message made of the ASCII characters "123456789" (each character MSB first) yields a check sequence of 0x31C3.
- R2: A bit taken with both `sof` and `bit_vld` high starts a frame. The remainder register is treated as all zeros before that first bit is folded in, so a frame never depends on the frame before it.
- R3: A bit is taken only in a cycle where `bit_vld` is high. Idle cycles inside a frame leave the result unchanged. Bits offered outside a frame without `sof` are ignored: they produce no output and do not alter the next frame.
- R4: In generate mode (`mode_chk`=0), each accepted message bit appears on `ser_out`, with `ser_vld` high, one cycle after it is sampled.
- R5: In generate mode, the remainder follows the echo of the last message bit (the bit marked `eom`) with no gap. It is sent as exactly W bits, MSB first, on consecutive cycles, and `ser_vld` then goes low.
- R6: While the remainder is being sent, every input (`bit_vld`, `bit_in`, `sof`, `eom`) is ignored.
- R7: In check mode (`mode_chk`=1), `chk_done` pulses high for exactly one cycle, one cycle after the `eom` bit is sampled. In that same cycle, `crc_err` is 1 exactly when the remainder over the whole frame is nonzero. `ser_vld` stays low throughout a check frame.
- R8: `crc_err` keeps its value until the next check result is delivered.
- R9: After synchronous reset, `ser_out`, `ser_vld`, `chk_done` and `crc_err` are all 0 and no frame is open.
- R10: The mode is sampled only on the start bit. Changing `mode_chk` later in the frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_chk | input | 1 | 0 = generate, 1 = check; sampled with the start bit |
| sof | input | 1 | Marks the first bit of a frame |
| eom | input | 1 | Marks the last bit fed in (message in generate mode, frame in check mode) |
| bit_vld | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Serial data in, MSB first |
| ser_out | output | 1 | Serial data out: the echoed message, then the check sequence |
| ser_vld | output | 1 | Qualifies `ser_out` |
| chk_done | output | 1 | One-cycle pulse when a check result is ready |
| crc_err | output | 1 | Result of the last check: 1 = nonzero remainder |

## Verification
Every output passes through one register stage.

In generate mode:
- An echoed bit is due one cycle after it is sampled.
- The W check bits follow on the W cycles right after the echo of the `eom` bit.
- The bench captures `ser_out` on falling edges whenever `ser_vld` is high. After a fixed wait of W+4 cycles, it compares both the length of the captured stream and its contents.

In check mode:
- The bench samples `chk_done` and `crc_err` on the falling edge just after the rising edge that takes the `eom` bit.
- It confirms that `chk_done` is low again one cycle later.
- It confirms that `crc_err` still holds its value several cycles after that.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

  typedef enum logic [1:0] {
    CRC_12    = 2'd0,
    CRC_16    = 2'd1,
    CRC_CCITT = 2'd2,
    CRC_32    = 2'd3
  } crc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MSG   = 2'd1,
    ST_FLUSH = 2'd2
  } crc_state_e;

  // Register width equals the degree of the generator.
  function automatic int crc_width(crc_kind_e k);
    case (k)
      CRC_12:  return 12;
      CRC_16:  return 16;
      CRC_32:  return 32;
      default: return 16;
    endcase
  endfunction

  // Generator taps with the top term left implicit.
  function automatic logic [31:0] crc_poly(crc_kind_e k);
    case (k)
      CRC_12:  return 32'h0000_080F;
      CRC_16:  return 32'h0000_8005;
      CRC_32:  return 32'h04C1_1DB7;
      default: return 32'h0000_1021;
    endcase
  endfunction

endpackage

// File: rtl/crc_shift_reg.sv
module crc_shift_reg
  #(parameter int W = 16,
    parameter logic [W-1:0] POLY = 16'h1021)
  (input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         shift_en,
   input  logic         flush,
   input  logic         din,
   output logic [W-1:0] rem_q,
   output logic [W-1:0] rem_nxt);

  logic [W-1:0] base;
  logic [W-1:0] step;
  logic         fb;

  // A frame's first bit is folded into an all-zero register.
  assign base = clr ? '0 : rem_q;
  assign fb   = din ^ base[W-1];

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
        assign step[0] = POLY[0] & fb;
      end else begin : g_mid
        assign step[i] = base[i-1] ^ (POLY[i] & fb);
      end
    end
  endgenerate

  always_comb begin
    if (flush)         rem_nxt = {rem_q[W-2:0], 1'b0};
    else if (shift_en) rem_nxt = step;
    else               rem_nxt = rem_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rem_q <= '0;
    else     rem_q <= rem_nxt;
  end

endmodule

// File: rtl/crc_frame_ctrl.sv
module crc_frame_ctrl
  import crc_serial_pkg::*;
  #(parameter int W = 16)
  (input  logic clk,
   input  logic rst,
   input  logic bit_vld,
   input  logic sof,
   input  logic eom,
   input  logic mode_chk,
   output logic accept,
   output logic start,
   output logic flush_en,
   output logic cur_mode,
   output logic frame_end);

  localparam int CW = $clog2(W + 1);

  crc_state_e    st_q, st_d;
  logic          mode_q;
  logic [CW-1:0] cnt_q;

  always_comb begin
    cur_mode  = (st_q == ST_IDLE) ? mode_chk : mode_q;
    start     = (st_q == ST_IDLE) && bit_vld && sof;
    accept    = start || ((st_q == ST_MSG) && bit_vld);
    frame_end = accept && eom;
    flush_en  = (st_q == ST_FLUSH);
    st_d      = st_q;
    case (st_q)
      ST_IDLE, ST_MSG: begin
        if (frame_end)   st_d = cur_mode ? ST_IDLE : ST_FLUSH;
        else if (accept) st_d = ST_MSG;
      end
      ST_FLUSH: begin
        if (cnt_q == CW'(W - 1)) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q <= st_d;
      if (start) mode_q <= mode_chk;
      cnt_q <= flush_en ? cnt_q + CW'(1) : '0;
    end
  end

endmodule

// File: rtl/serial_crc_engine.sv
module serial_crc_engine
  import crc_serial_pkg::*;
  #(parameter crc_kind_e KIND = CRC_CCITT)
  (input  logic clk,
   input  logic rst,
   input  logic mode_chk,
   input  logic sof,
   input  logic eom,
   input  logic bit_vld,
   input  logic bit_in,
   output logic ser_out,
   output logic ser_vld,
   output logic chk_done,
   output logic crc_err);

  localparam int          W         = crc_width(KIND);
  localparam logic [31:0] POLY_FULL = crc_poly(KIND);
  localparam logic [W-1:0] POLY     = POLY_FULL[W-1:0];

  logic         accept, start, flush_en, cur_mode, frame_end;
  logic [W-1:0] rem_q, rem_nxt;
  logic         gen_bit;

  crc_frame_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bit_vld   (bit_vld),
    .sof       (sof),
    .eom       (eom),
    .mode_chk  (mode_chk),
    .accept    (accept),
    .start     (start),
    .flush_en  (flush_en),
    .cur_mode  (cur_mode),
    .frame_end (frame_end)
  );

  crc_shift_reg #(.W(W), .POLY(POLY)) u_reg (
    .clk      (clk),
    .rst      (rst),
    .clr      (start),
    .shift_en (accept),
    .flush    (flush_en),
    .din      (bit_in),
    .rem_q    (rem_q),
    .rem_nxt  (rem_nxt)
  );

  assign gen_bit = accept && !cur_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out  <= 1'b0;
      ser_vld  <= 1'b0;
      chk_done <= 1'b0;
      crc_err  <= 1'b0;
    end else begin
      ser_vld  <= gen_bit || flush_en;
      ser_out  <= flush_en ? rem_q[W-1] : (gen_bit & bit_in);
      chk_done <= frame_end && cur_mode;
      if (frame_end && cur_mode) crc_err <= |rem_nxt;
    end
  end

endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk
  (input logic clk,
   input logic rst,
   input logic bit_vld,
   input logic eom,
   input logic ser_vld,
   input logic chk_done,
   input logic crc_err);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    chk_done |=> !chk_done); // R7

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    chk_done |-> $past(bit_vld && eom)); // R7

  AST_NO_STREAM_ON_CHECK: assert property (@(posedge clk) disable iff (rst)
    !(chk_done && ser_vld)); // R7

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
    !$stable(crc_err) |-> chk_done); // R8

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!ser_vld && !chk_done && !crc_err)); // R9

endmodule

bind serial_crc_engine crc_engine_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bit_vld  (bit_vld),
  .eom      (eom),
  .ser_vld  (ser_vld),
  .chk_done (chk_done),
  .crc_err  (crc_err)
);

// File: tb/serial_crc_engine_tb_top.sv
module serial_crc_engine_tb_top;

  localparam int          W     = 16;
  localparam logic [15:0] GPOLY = 16'h1021;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_chk = 1'b0, sof = 1'b0, eom = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic ser_out, ser_vld, chk_done, crc_err;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  logic [0:255] cap;
  int           cap_n = 0;
  logic         done_now, done_after;

  always #5 clk = ~clk;

  serial_crc_engine dut_i (
    .clk(clk), .rst(rst), .mode_chk(mode_chk), .sof(sof), .eom(eom),
    .bit_vld(bit_vld), .bit_in(bit_in), .ser_out(ser_out),
    .ser_vld(ser_vld), .chk_done(chk_done), .crc_err(crc_err));

  always @(negedge clk) begin
    if (ser_vld && cap_n < 256) begin
      cap[cap_n] = ser_out;
      cap_n++;
    end
  end

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Long division of the message padded with W zeros.
  function automatic logic [15:0] model(logic [0:255] m, int n);
    logic [15:0] r = '0;
    for (int i = 0; i < n + W; i++) begin
      logic top = r[15];
      r = {r[14:0], (i < n) ? m[i] : 1'b0};
      if (top) r ^= GPOLY;
    end
    return r;
  endfunction

  task automatic send(logic [0:255] m, int n, bit chk, bit gaps, bit junk);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        bit_vld = 1'b0; bit_in = 1'b1; sof = 1'b0; eom = 1'b1;
      end
      @(negedge clk);
      bit_vld = 1'b1; bit_in = m[i];
      sof = (i == 0); eom = (i == n - 1);
      mode_chk = (i == 0) ? chk : ~chk;  // later levels must be ignored (R10)
    end
    if (junk) begin
      for (int j = 0; j < W; j++) begin
        @(negedge clk);
        bit_vld = 1'b1; bit_in = 1'b1; sof = 1'b1; eom = (j % 2 == 0);
      end
    end
    @(negedge clk);
    bit_vld = 1'b0; sof = 1'b0; eom = 1'b0; bit_in = 1'b0; mode_chk = 1'b0;
    done_now = chk_done;
    @(negedge clk);
    done_after = chk_done;
  endtask

  task automatic run_gen(string tag, logic [0:255] m, int n, bit gaps, bit junk,
                         logic [15:0] fixed_exp, bit use_fixed);
    logic [15:0] exp_fcs, got;
    cap_n = 0;
    send(m, n, 1'b0, gaps, junk);
    repeat (W + 4) @(negedge clk);
    exp_fcs = use_fixed ? fixed_exp : model(m, n);
    check({tag, " R5 stream length"}, cap_n, n + W);
    for (int i = 0; i < n; i++)
      if (cap[i] != m[i]) begin
        check({tag, " R4 echo bit"}, i, -1);
        break;
      end
    for (int j = 0; j < W; j++) got[W-1-j] = cap[n+j];
    check({tag, " R5 check sequence"}, got, exp_fcs);
  endtask

  task automatic run_chk(string tag, logic [0:255] m, int n, int flip);
    logic [0:255] f = m;
    logic [15:0] fcs = model(m, n);
    for (int j = 0; j < W; j++) f[n+j] = fcs[W-1-j];
    if (flip >= 0) f[flip] = ~f[flip];
    cap_n = 0;
    send(f, n + W, 1'b1, 1'b0, 1'b0);
    check({tag, " R7 done one cycle after last bit"}, done_now, 1);
    check({tag, " R7 done pulse ends"}, done_after, 0);
    check({tag, " R7 no stream in check mode"}, cap_n, 0);
    repeat (5) @(negedge clk);
    check({tag, " R8 R7 error flag held"}, crc_err, (flip >= 0) ? 1 : 0);
  endtask

  initial begin
    logic [0:255] m;
    string s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 ser_vld after reset", ser_vld, 0);
    check("R9 ser_out after reset", ser_out, 0);
    check("R9 chk_done after reset", chk_done, 0);
    check("R9 crc_err after reset", crc_err, 0);

    // Known anchor value for the default generator.
    s = "123456789";
    m = '0;
    for (int i = 0; i < 9; i++) m[i*8 +: 8] = s[i];
    run_gen("R1 ascii", m, 72, 1'b0, 1'b0, 16'h31C3, 1'b1);

    // Bits outside any frame, then a frame.
    cap_n = 0;
    repeat (5) begin
      @(negedge clk); bit_vld = 1'b1; bit_in = 1'b1; eom = 1'b1;
    end
    @(negedge clk); bit_vld = 1'b0; eom = 1'b0; bit_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 idle bits produce no output", cap_n, 0);
    m = '0; m[0:39] = 40'hA53C0FF096;
    run_gen("R3 after idle bits", m, 40, 1'b0, 1'b0, '0, 1'b0);

    // Gapped input, then inputs driven during the remainder phase.
    run_gen("R3 gaps", m, 40, 1'b1, 1'b0, '0, 1'b0);
    m = '0; m[0:23] = 24'hFFFFFF;
    run_gen("R6 inputs during flush", m, 24, 1'b0, 1'b1, '0, 1'b0);
    // Back-to-back frame: must match a fresh computation.
    run_gen("R2 next frame", m, 24, 1'b0, 1'b0, '0, 1'b0);
    m = '0; m[0] = 1'b1;
    run_gen("R2 one-bit message", m, 1, 1'b0, 1'b0, '0, 1'b0);

    // Check mode.
    m = '0; m[0:39] = 40'hA53C0FF096;
    run_chk("clean frame", m, 40, -1);
    run_chk("corrupt data bit", m, 40, 7);
    run_chk("corrupt check bit", m, 40, 40 + 3);
    s = "123456789";
    m = '0;
    for (int i = 0; i < 9; i++) m[i*8 +: 8] = s[i];
    run_chk("R1 ascii clean", m, 72, -1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule